// File: doc/BRIEF.md
# Predicated Vector-Loop Add Sequencer

This block expands a single scalar integer add into a loop of up to 64 element operations over a shared file of 32 registers, each 64 bits wide. A start request gives the element count, the number of the register that holds the per-element enable mask, the base register numbers of the destination and of both sources, and one "vectorised" flag per operand. A flagged operand walks forward one register per element. An unflagged operand stays on its base register. The same add therefore covers the scalar-scalar, scalar-vector and vector-vector forms.

The sequencer handles one element per clock. In each element cycle it reads both sources, adds them, and writes the sum only when that element's mask bit is set. Masked elements still advance the operand offsets. A one-cycle done pulse marks the end of the loop. A host port loads and inspects registers while the block is idle.

Top module: `vec_loop_seq`

## Requirements
- R1: After reset, busy and done are 0 and every register reads back 0 on the host port.
- R2: A start accepted with element count VL (1..64) performs elements 0..VL-1 in order, one per clock. Each enabled element writes the 64-bit wrapping sum of its two source registers into its destination register. Done is high in the cycle VL+1 clocks after the accepting edge.
- R3: Element i writes only when bit i of the mask register is 1. An element whose bit is 0 writes nothing.
- R4: Operand register number = base + i when that operand's flag is set, otherwise base. Offsets advance on masked elements too. The flag bus is {dst, src1, src2} with bit 2 for the destination.
- R5: Register numbers wrap modulo 32, so base 30 at element 3 addresses register 1.
- R6: An element that reads a register written by an earlier element of the same loop sees the new value.
- R7: A start with VL=0 raises done exactly one clock after the accepting edge and writes nothing.
- R8: Busy is high from the accepting edge through the done cycle. Done lasts one cycle. A start request while busy is ignored.
- R9: Host writes while busy have no effect. When idle, a host write updates the addressed register at the clock edge, and the host read returns the addressed register combinationally.
- R10: The mask register is sampled once at the accepting edge. Writes to that register during the loop do not change which elements are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start request, taken only when idle |
| startVl | input | 7 | Element count 0..64 (larger values clamp to 64) |
| predSel | input | 5 | Register holding the element enable mask |
| dstBase | input | 5 | Destination base register |
| src1Base | input | 5 | First source base register |
| src2Base | input | 5 | Second source base register |
| vecFlags | input | 3 | Vectorised flags {dst, src1, src2} |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle end-of-loop pulse |
| hostWrEn | input | 1 | Host register write enable |
| hostAddr | input | 5 | Host register address |
| hostWrData | input | 64 | Host write data |
| hostRdData | output | 64 | Contents of register hostAddr |

## Verification
Fixed vectors separate the cases that a single full-mask, all-vector loop cannot tell apart. A sparse mask tells a skipped element from a written one. Splat and mixed-flag forms show whether each operand index advances on its own. A loop starting at base 30 exposes a missing wrap. A chain where the destination runs one register ahead of a source shows whether a write is forwarded to the next element. A loop whose scalar destination is the mask register separates start-time sampling from live reads. Random count, mask and flag combinations follow, each checked against a sequential software loop over all 32 registers. Directed runs cover VL=0, a start request during a loop and a host write during a loop.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef struct packed {
    logic load;   // accept start: latch operands, clear offsets
    logic step;   // one element cycle
    logic wrEn;   // element enabled by mask
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seqState_t;
endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int DATA_W = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [VL_W-1:0]   startVl,
  input  logic [DATA_W-1:0] predValue,
  output seqStrobe_t        strobe,
  output logic              busy,
  output logic              done
);
  seqState_t         state;
  logic [IDX_W-1:0]  elemIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic [DATA_W-1:0] maskQ;
  logic [VL_W-1:0]   vlClamped;

  assign vlClamped = (startVl > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : startVl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      elemIdx <= '0;
      lastIdx <= '0;
      maskQ   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          maskQ   <= predValue;
          elemIdx <= '0;
          lastIdx <= IDX_W'(vlClamped - VL_W'(1));
          state   <= (vlClamped == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          elemIdx <= elemIdx + IDX_W'(1);
          if (elemIdx == lastIdx) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load = (state == ST_IDLE) && startReq;
    strobe.step = (state == ST_RUN);
    strobe.wrEn = (state == ST_RUN) && maskQ[elemIdx];
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_zero_vl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq && startVl == '0) |=> done);
  assert_mask_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(maskQ));
endmodule

// File: rtl/vseq_datapath.sv
module vseq_datapath
  import vseq_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  localparam int REG_AW  = $clog2(NUM_REGS),
  localparam int N_OPS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic              busy,
  input  logic [REG_AW-1:0] dstBase,
  input  logic [REG_AW-1:0] src1Base,
  input  logic [REG_AW-1:0] src2Base,
  input  logic [N_OPS-1:0]  vecFlags,
  input  logic [REG_AW-1:0] predSel,
  output logic [DATA_W-1:0] predValue,
  input  logic              hostWrEn,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData
);
  // operand slot 2 = destination, 1 = source 1, 0 = source 2
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [REG_AW-1:0] opBaseIn [N_OPS];
  logic [REG_AW-1:0] opBase   [N_OPS];
  logic [REG_AW-1:0] opOff    [N_OPS];
  logic              opVec    [N_OPS];
  logic [REG_AW-1:0] opIdx    [N_OPS];
  logic [DATA_W-1:0] elemSum;

  assign opBaseIn[2] = dstBase;
  assign opBaseIn[1] = src1Base;
  assign opBaseIn[0] = src2Base;

  for (genvar g = 0; g < N_OPS; g++) begin : gOperand
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        opBase[g] <= '0;
        opOff[g]  <= '0;
        opVec[g]  <= 1'b0;
      end else if (strobe.load) begin
        opBase[g] <= opBaseIn[g];
        opOff[g]  <= '0;
        opVec[g]  <= vecFlags[g];
      end else if (strobe.step && opVec[g]) begin
        opOff[g]  <= opOff[g] + REG_AW'(1);
      end
    end
    assign opIdx[g] = opBase[g] + opOff[g];

    assert_scalar_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.step && !opVec[g]) |=> $stable(opIdx[g]));
  end

  assign elemSum = regFile[opIdx[1]] + regFile[opIdx[0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++) regFile[k] <= '0;
    end else if (strobe.wrEn) begin
      regFile[opIdx[2]] <= elemSum;
    end else if (hostWrEn && !busy) begin
      regFile[hostAddr] <= hostWrData;
    end
  end

  assign predValue  = regFile[predSel];
  assign hostRdData = regFile[hostAddr];

  assert_step_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.step |-> busy);
endmodule

// File: rtl/vec_loop_seq.sv
module vec_loop_seq
  import vseq_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  parameter int MAX_VL   = 64,
  localparam int REG_AW  = $clog2(NUM_REGS),
  localparam int VL_W    = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [VL_W-1:0]   startVl,
  input  logic [REG_AW-1:0] predSel,
  input  logic [REG_AW-1:0] dstBase,
  input  logic [REG_AW-1:0] src1Base,
  input  logic [REG_AW-1:0] src2Base,
  input  logic [2:0]        vecFlags,
  output logic              busy,
  output logic              done,
  input  logic              hostWrEn,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData
);
  seqStrobe_t        strobe;
  logic [DATA_W-1:0] predValue;

  vseq_ctrl #(.MAX_VL(MAX_VL), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .startVl(startVl),
    .predValue(predValue), .strobe(strobe), .busy(busy), .done(done)
  );

  vseq_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .busy(busy),
    .dstBase(dstBase), .src1Base(src1Base), .src2Base(src2Base),
    .vecFlags(vecFlags), .predSel(predSel), .predValue(predValue),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData)
  );
endmodule

// File: tb/vec_loop_seq_tb.sv
`timescale 1ns/1ps
module vec_loop_seq_tb_top;
  typedef struct packed {
    logic [6:0]  vl;
    logic [4:0]  pr;
    logic [4:0]  d;
    logic [4:0]  a;
    logic [4:0]  b;
    logic [2:0]  flags;   // {dst, src1, src2}
    logic [63:0] mask;
    logic [7:0]  expLat;  // clocks from accepting edge to done
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{7'd8,  5'd1, 5'd10, 5'd2,  5'd20, 3'b111, 64'h00000000000000A5, 8'd9},  // R2 R3 sparse
    '{7'd5,  5'd3, 5'd8,  5'd4,  5'd0,  3'b101, 64'hFFFFFFFFFFFFFFFF, 8'd6},  // R4 scalar src1
    '{7'd4,  5'd6, 5'd14, 5'd9,  5'd9,  3'b100, 64'h000000000000000F, 8'd5},  // R4 splat
    '{7'd6,  5'd4, 5'd30, 5'd28, 5'd29, 3'b111, 64'h000000000000003F, 8'd7},  // R5 wrap
    '{7'd6,  5'd5, 5'd11, 5'd10, 5'd1,  3'b110, 64'hFFFFFFFFFFFFFFFF, 8'd7},  // R6 chain
    '{7'd4,  5'd7, 5'd7,  5'd12, 5'd13, 3'b010, 64'h000000000000000B, 8'd5},  // R10 mask overwritten
    '{7'd64, 5'd2, 5'd0,  5'd3,  5'd5,  3'b111, 64'hF0F0F0F00F0F0F0F, 8'd65}, // R2 max VL, R5
    '{7'd1,  5'd9, 5'd15, 5'd16, 5'd17, 3'b111, 64'h0000000000000000, 8'd2}   // R3 all masked
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic startReq = 1'b0;
  logic [6:0]  startVl = '0;
  logic [4:0]  predSel = '0, dstBase = '0, src1Base = '0, src2Base = '0;
  logic [2:0]  vecFlags = '0;
  logic busy, done;
  logic hostWrEn = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [63:0] hostWrData = '0, hostRdData;

  logic [63:0] mdl [32];
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vec_loop_seq dut_i (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .startVl(startVl),
    .predSel(predSel), .dstBase(dstBase), .src1Base(src1Base), .src2Base(src2Base),
    .vecFlags(vecFlags), .busy(busy), .done(done), .hostWrEn(hostWrEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [4:0] addr, input logic [63:0] data);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = addr; hostWrData = data;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic loadRegs(input int seed);
    for (int k = 0; k < 32; k++) begin
      logic [63:0] v;
      v = {32'(seed * 977 + k * 131), 32'(k * 32'h1111 ^ seed)};
      hostWrite(5'(k), v);
      mdl[k] = v;
    end
  endtask

  task automatic checkRegs(input string req);
    @(negedge clk);
    for (int k = 0; k < 32; k++) begin
      hostAddr = 5'(k); #0.1;
      check(hostRdData == mdl[k], req, hostRdData, mdl[k]);
    end
  endtask

  // sequential software model of the loop
  task automatic modelOp(input int vl, input int pr, input int d, input int a, input int b, input logic [2:0] fl);
    logic [63:0] m;
    m = mdl[pr];
    for (int i = 0; i < vl; i++) begin
      if (m[i]) mdl[(d + (fl[2] ? i : 0)) % 32] = mdl[(a + (fl[1] ? i : 0)) % 32] + mdl[(b + (fl[0] ? i : 0)) % 32];
    end
  endtask

  task automatic runOp(input int vl, input int pr, input int d, input int a, input int b,
                       input logic [2:0] fl, input int expLat, input bit intrude, input string req);
    int cycles;
    modelOp(vl, pr, d, a, b, fl);
    @(negedge clk);
    startReq = 1'b1; startVl = 7'(vl); predSel = 5'(pr);
    dstBase = 5'(d); src1Base = 5'(a); src2Base = 5'(b); vecFlags = fl;
    @(posedge clk); #1;
    startReq = 1'b0;
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
      if (!done) check(busy == 1'b1, {req, " R8 busy during loop"}, 64'(busy), 64'd1);
      if (intrude && cycles == 2) begin
        startReq = 1'b1; startVl = 7'd3; dstBase = 5'd26; src1Base = 5'd1; vecFlags = 3'b111;
        hostWrEn = 1'b1; hostAddr = 5'd25; hostWrData = 64'hDEAD_BEEF_0BAD_F00D;
      end else begin
        startReq = 1'b0; hostWrEn = 1'b0;
      end
    end while (!done && cycles < 200);
    startReq = 1'b0; hostWrEn = 1'b0;
    check(cycles == expLat, {req, " R2 done latency"}, 64'(cycles), 64'(expLat));
    check(busy == 1'b1, {req, " R8 busy in done cycle"}, 64'(busy), 64'd1);
    @(negedge clk);
    check(done == 1'b0, {req, " R8 done single cycle"}, 64'(done), 64'd0);
    check(busy == 1'b0, {req, " R8 idle after done"}, 64'(busy), 64'd0);
    checkRegs(req);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
    check(done == 1'b0, "R1 done", 64'(done), 64'd0);
    for (int k = 0; k < 32; k++) mdl[k] = '0;
    checkRegs("R1 reset registers");

    // table of vectors
    for (int t = 0; t < NV; t++) begin
      loadRegs(t + 1);
      hostWrite(TBL[t].pr, TBL[t].mask);
      mdl[TBL[t].pr] = TBL[t].mask;
      runOp(int'(TBL[t].vl), int'(TBL[t].pr), int'(TBL[t].d), int'(TBL[t].a), int'(TBL[t].b),
            TBL[t].flags, int'(TBL[t].expLat), 1'b0, $sformatf("R2 R3 R4 R5 R6 R10 vector %0d", t));
    end

    // random combinations
    for (int r = 0; r < 30; r++) begin
      int vl, pr, d, a, b;
      logic [2:0] fl;
      logic [63:0] m;
      vl = int'($urandom_range(0, 64));
      pr = int'($urandom % 32); d = int'($urandom % 32);
      a = int'($urandom % 32); b = int'($urandom % 32);
      fl = 3'($urandom); m = {$urandom, $urandom};
      loadRegs(100 + r);
      hostWrite(5'(pr), m);
      mdl[pr] = m;
      runOp(vl, pr, d, a, b, fl, vl + 1, 1'b0, "R2 R3 R4 random");
    end

    // R7 zero element count
    loadRegs(200);
    runOp(0, 0, 3, 4, 5, 3'b111, 1, 1'b0, "R7 zero VL");

    // R8 start while busy, R9 host write while busy (reg 25 not touched by loop)
    loadRegs(300);
    hostWrite(5'd8, 64'hF);
    mdl[8] = 64'hF;
    runOp(4, 8, 10, 2, 3, 3'b111, 5, 1'b1, "R8 R9 intrusion during loop");

    // R9 idle host write and combinational read
    hostWrite(5'd25, 64'h0123_4567_89AB_CDEF);
    @(negedge clk);
    hostAddr = 5'd25; #0.1;
    check(hostRdData == 64'h0123_4567_89AB_CDEF, "R9 idle host write", hostRdData, 64'h0123_4567_89AB_CDEF);

    finished = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end
endmodule